// File: doc/BRIEF.md
# Clock-jitter entropy seed collector

This block turns the phase wander between two unrelated clocks into seed material for a 32-bit pseudo-random generator. A flip-flop driven by the first source clock inverts itself on every rising edge. A counter on the second source clock divides that clock down, and on each divided event it samples the flip-flop. XORing the new sample with the previous one gives the parity of the number of first-clock edges since the last event, which is one raw bit per event.

Each raw bit is moved into the system clock domain as a held data bit plus a flag that changes state once per event. The flag passes through a synchronizer chain. When the block sees the flag change, the raw bit is folded into the feedback of a maximal-length shift register during one shift. The bits go straight into the register, one at a time, with no staging word. A flag marks the point where a full register width of raw bits has been absorbed.

Consumers ask for words through a valid/ready request channel that carries a length. The requester holds `req_valid` and `req_len` steady until `req_ready` is high on a rising clock edge. `req_ready` stays low for the whole time a word is being built, and a request made in that time is not taken. The result comes back as a one-cycle `rnd_valid` pulse. That output has no back-pressure, so the consumer must capture `rnd_out` in the pulse cycle or later, before the next request completes.

Top module: `jit_seed_top`

## Requirements
- R1: The first-source flip-flop inverts on every rising edge of `src_a_clk` after reset. The raw bit of each event is 1 exactly when an odd number of `src_a_clk` rising edges occurred since the previous event, or since reset for the first event.
- R2: An event happens on every DIV-th rising edge of `src_b_clk` counted from reset (DIV defaults to 16), so the first event falls on the 16th edge.
- R3: Each event injects exactly one bit into the shift register, on the third rising edge of `clk` after the event (a two-flop synchronizer followed by one edge-detect flop).
- R4: The shift register resets to 1. One shift moves bits 30..0 up to 31..1 and puts into bit 0 the XOR of bits 31, 21, 1 and 0 with the injected bit (0 if none). A result of all zeros is replaced by 1. The register changes only on a shift.
- R5: `seed_valid` is 0 from reset until 32 bits have been injected, goes to 1 on the clock edge of the 32nd injection, and then stays at 1.
- R6: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 when the block is idle and 0 from the edge after acceptance until the word has been delivered. A `req_len` of 0 asks for 32 bits; otherwise it asks for `req_len` bits.
- R7: After a request for n bits is accepted, the register shifts once on each of the next n edges. On the n-th of these edges `rnd_valid` goes high for exactly one cycle. In that cycle `rnd_out` holds bits n-1..0 of the register after the last shift, and all bits above n-1 are 0.
- R8: When an injection arrives on the same edge as a shift for a request, that edge does a single shift that includes the injected bit, and the shift counts toward the request.
- R9: While `req_ready` is 0, `req_valid` and `req_len` have no effect on the word in progress or on its timing.
- R10: During reset and until the first request, `req_ready` is 1, `rnd_valid` is 0, `seed_valid` is 0 and `rnd_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the request channel and the shift register |
| rst_n | input | 1 | Asynchronous active-low reset for all three clock domains |
| src_a_clk | input | 1 | First entropy clock; drives the toggling flip-flop |
| src_b_clk | input | 1 | Second entropy clock; divided to set the sampling events |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request on this edge |
| req_len | input | 5 | Requested bit count; 0 means 32 |
| rnd_valid | output | 1 | One-cycle pulse marking a finished word |
| rnd_out | output | 32 | Finished word, right-aligned, with the upper bits cleared |
| seed_valid | output | 1 | At least 32 entropy bits have been absorbed |

## Verification
The bench drives the two source clocks with unrelated, offset periods so that their edges never coincide. It keeps its own count of first-clock edges at each divided second-clock event, and from that count it builds the expected bit stream and the expected register contents. Word lengths of 1 and of 0 (meaning 32) are aimed at mask and length decoding. A design that shifts once too often or too seldom, or that leaves stale upper bits, returns a wrong word or delivers it on the wrong cycle. Random request timing makes injections land inside active words. A design that shifts twice on those edges, or drops the bit, moves away from the expected register contents from then on. Holding `req_valid` high through a busy period checks that a second request is not taken, which would otherwise shorten or restart the word. The bench also tracks when `seed_valid` rises, to catch an off-by-one count of absorbed bits.

// File: rtl/jit_seed_pkg.sv
`timescale 1ns/1ps
package jit_seed_pkg;
  parameter int unsigned LFSR_W = 32;
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;
  parameter logic [LFSR_W-1:0] LFSR_INIT = 32'h0000_0001;
  localparam int unsigned LEN_W = $clog2(LFSR_W);

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [LEN_W:0]    steps_t;
  typedef enum logic {GEN_IDLE, GEN_RUN} gen_state_e;

  // one shift with optional injected bit; all-zero result is replaced
  function automatic lfsr_t lfsr_advance(lfsr_t cur, logic inject);
    lfsr_t nxt;
    logic  fb;
    fb  = (^(cur & LFSR_TAPS)) ^ inject;
    nxt = {cur[LFSR_W-2:0], fb};
    if (nxt == '0) nxt = LFSR_INIT;
    return nxt;
  endfunction

  // ones in the lowest n positions
  function automatic lfsr_t low_mask(steps_t n);
    lfsr_t m;
    for (int i = 0; i < LFSR_W; i++) m[i] = (steps_t'(i) < n);
    return m;
  endfunction
endpackage

// File: rtl/ent_capture.sv
`timescale 1ns/1ps
module ent_capture #(
  parameter int unsigned DIV = 16
) (
  input  logic src_a_clk,
  input  logic src_b_clk,
  input  logic rst_n,
  output logic raw_bit,
  output logic evt_flag
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

  // free-running toggle in the first source domain
  logic tog_q;
  always_ff @(posedge src_a_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  // divider and parity capture in the second source domain
  logic [CNT_W-1:0] div_q;
  logic             last_q;
  logic             raw_q;
  logic             evt_q;
  logic             wrap;

  assign wrap = (div_q == CNT_LAST);

  always_ff @(posedge src_b_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      last_q <= 1'b0;
      raw_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else if (wrap) begin
      div_q  <= '0;
      last_q <= tog_q;
      raw_q  <= tog_q ^ last_q;
      evt_q  <= ~evt_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  assign raw_bit  = raw_q;
  assign evt_flag = evt_q;

  AST_EVT_ONLY_ON_WRAP: assert property (@(posedge src_b_clk) disable iff (!rst_n)
    !wrap |=> $stable(evt_q)); // R2
  AST_EVT_ON_WRAP: assert property (@(posedge src_b_clk) disable iff (!rst_n)
    wrap |=> (evt_q != $past(evt_q))); // R2
  AST_RAW_HELD: assert property (@(posedge src_b_clk) disable iff (!rst_n)
    !wrap |=> $stable(raw_q)); // R1
endmodule

// File: rtl/ent_sync.sv
`timescale 1ns/1ps
module ent_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_bit,
  input  logic evt_flag,
  output logic take,
  output logic take_bit
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain_q;
  logic            bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      bit_q   <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-1:0], evt_flag};
      bit_q   <= raw_bit; // raw_bit is held for many clk cycles around each flag change
    end
  end

  assign take     = chain_q[STAGES] ^ chain_q[STAGES-1];
  assign take_bit = bit_q;

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take); // R3
endmodule

// File: rtl/seed_lfsr.sv
`timescale 1ns/1ps
module seed_lfsr
  import jit_seed_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  inject_en,
  input  logic  inject_bit,
  output lfsr_t state_nxt,
  output logic  seed_valid
);
  localparam logic [LEN_W:0] FULL = (LEN_W+1)'(LFSR_W);

  lfsr_t          state_q;
  logic [LEN_W:0] abs_q;

  assign state_nxt = lfsr_advance(state_q, inject_en & inject_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LFSR_INIT;
      abs_q   <= '0;
    end else begin
      if (step) state_q <= state_nxt;
      if (inject_en && abs_q != FULL) abs_q <= abs_q + 1'b1;
    end
  end

  assign seed_valid = (abs_q == FULL);

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q)); // R4
  AST_SEED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(seed_valid)); // R5
endmodule

// File: rtl/gen_ctrl.sv
`timescale 1ns/1ps
module gen_ctrl
  import jit_seed_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  input  lfsr_t            state_nxt,
  output logic             busy,
  output logic             rnd_valid,
  output lfsr_t            rnd_out
);
  gen_state_e st_q;
  steps_t     rem_q;
  steps_t     len_n;
  lfsr_t      mask_q;
  lfsr_t      out_q;
  logic       valid_q;

  assign len_n = (req_len == '0) ? steps_t'(LFSR_W) : {1'b0, req_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= GEN_IDLE;
      rem_q   <= '0;
      mask_q  <= '0;
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (st_q)
        GEN_IDLE: begin
          if (req_valid) begin
            st_q   <= GEN_RUN;
            rem_q  <= len_n;
            mask_q <= low_mask(len_n);
          end
        end
        GEN_RUN: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == steps_t'(1)) begin
            st_q    <= GEN_IDLE;
            valid_q <= 1'b1;
            out_q   <= state_nxt & mask_q;
          end
        end
        default: st_q <= GEN_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == GEN_IDLE);
  assign busy      = (st_q == GEN_RUN);
  assign rnd_valid = valid_q;
  assign rnd_out   = out_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |=> !rnd_valid); // R7
  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |-> $past(busy)); // R7
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem_q != steps_t'(1)) |=> (busy && rem_q == $past(rem_q) - 1'b1)); // R9
endmodule

// File: rtl/jit_seed_top.sv
`timescale 1ns/1ps
module jit_seed_top
  import jit_seed_pkg::*;
#(
  parameter int unsigned DIV         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_a_clk,
  input  logic              src_b_clk,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rnd_valid,
  output logic [LFSR_W-1:0] rnd_out,
  output logic              seed_valid
);
  logic  raw_bit;
  logic  evt_flag;
  logic  take;
  logic  take_bit;
  logic  busy;
  lfsr_t state_nxt;

  ent_capture #(.DIV(DIV)) u_capture (
    .src_a_clk (src_a_clk),
    .src_b_clk (src_b_clk),
    .rst_n     (rst_n),
    .raw_bit   (raw_bit),
    .evt_flag  (evt_flag)
  );

  ent_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_bit  (raw_bit),
    .evt_flag (evt_flag),
    .take     (take),
    .take_bit (take_bit)
  );

  seed_lfsr u_lfsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (busy | take),
    .inject_en  (take),
    .inject_bit (take_bit),
    .state_nxt  (state_nxt),
    .seed_valid (seed_valid)
  );

  gen_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_len   (req_len),
    .state_nxt (state_nxt),
    .busy      (busy),
    .rnd_valid (rnd_valid),
    .rnd_out   (rnd_out)
  );
endmodule

// File: tb/jit_seed_top_tb.sv
`timescale 1ns/1ps
module jit_seed_top_tb;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        src_a = 1'b0;
  logic        src_b = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_len = '0;
  logic        req_ready;
  logic        rnd_valid;
  logic [31:0] rnd_out;
  logic        seed_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  jit_seed_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_a_clk  (src_a),
    .src_b_clk  (src_b),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_len    (req_len),
    .rnd_valid  (rnd_valid),
    .rnd_out    (rnd_out),
    .seed_valid (seed_valid)
  );

  // 125 MHz system clock; source clocks unrelated and offset so no edges coincide
  always #4 clk = ~clk;
  initial begin #1.1;  forever begin src_a = 1'b1; #3.65; src_a = 1'b0; #3.65; end end
  initial begin #0.37; forever begin src_b = 1'b1; #5.55; src_b = 1'b0; #5.55; end end

  // shift rule written from R4
  function automatic logic [31:0] model_step(logic [31:0] s, logic b);
    logic [31:0] r;
    r = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0] ^ b};
    if (r == 32'h0) r = 32'h1;
    return r;
  endfunction

  function automatic logic [31:0] model_mask(int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  // R1/R2 model: count first-source edges, parity at every DIV-th second-source edge
  int unsigned n_a = 0;
  int unsigned b_cnt = 0;
  int unsigned a_at_evt = 0;
  logic ev_m = 1'b0;
  logic bit_m = 1'b0;

  always @(posedge src_a or negedge rst_n) begin
    if (!rst_n) n_a = 0;
    else        n_a = n_a + 1;
  end

  always @(posedge src_b or negedge rst_n) begin
    if (!rst_n) begin
      b_cnt = 0; a_at_evt = 0; ev_m = 1'b0; bit_m = 1'b0;
    end else if (b_cnt == DIV - 1) begin
      b_cnt    = 0;
      bit_m    = ((n_a - a_at_evt) % 2) == 1;
      a_at_evt = n_a;
      ev_m     = ~ev_m;
    end else begin
      b_cnt = b_cnt + 1;
    end
  end

  // R3..R8 model in the system domain
  logic [31:0] m_state = 32'h1;
  logic [31:0] m_mask = '0;
  logic [31:0] exp_word = '0;
  logic m1 = 1'b0, m2 = 1'b0, m3 = 1'b0, bq = 1'b0;
  logic tk, ib;
  int m_abs = 0;
  int rem_m = 0;
  int acc_req = 0;
  int acc_seen = 0;
  int acc_len = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      tk = m2 ^ m3;
      ib = bq;
      if (tk || rem_m > 0) m_state = model_step(m_state, tk & ib);
      if (tk && m_abs < 32) m_abs = m_abs + 1;
      if (rem_m > 0) begin
        rem_m = rem_m - 1;
        if (rem_m == 0) exp_word = m_state & m_mask;
      end else if (acc_req != acc_seen) begin
        acc_seen = acc_req;
        rem_m    = acc_len;
        m_mask   = model_mask(acc_len);
      end
      m3 = m2; m2 = m1; m1 = ev_m; bq = bit_m;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input int len_field, input bit hold_busy);
    int n;
    int k;
    bit got;
    n = (len_field == 0) ? 32 : len_field;
    @(negedge clk);
    chk(req_ready == 1'b1, "R6", "ready while idle", req_ready, 1);
    req_valid = 1'b1;
    req_len   = 5'(len_field);
    acc_len   = n;
    acc_req   = acc_req + 1;
    k = 0;
    got = 0;
    while (!got && k < n + 5) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        chk(req_ready == 1'b0, "R6", "ready low after accept", req_ready, 0);
        if (hold_busy) req_len = 5'(len_field + 3);
        else           req_valid = 1'b0;
      end
      if (hold_busy && k == n) req_valid = 1'b0; // R9: held through busy, dropped before the last shift
      if (rnd_valid) got = 1;
    end
    req_valid = 1'b0;
    chk(got && k == n + 1, "R7", "word latency", k, n + 1);
    chk(rnd_out == exp_word, "R1/R2/R3/R4/R7/R8/R9", "word value", rnd_out, exp_word);
    @(negedge clk);
    chk(rnd_valid == 1'b0, "R7", "pulse one cycle", rnd_valid, 0);
    chk(seed_valid == (m_abs >= 32), "R5", "seed flag", seed_valid, m_abs >= 32);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #50;
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    chk(rnd_valid == 1'b0, "R10", "reset pulse", rnd_valid, 0);
    chk(seed_valid == 1'b0, "R10", "reset seed flag", seed_valid, 0);
    chk(rnd_out == 32'h0, "R10", "reset word", rnd_out, 0);
    #52.3;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(seed_valid == 1'b0, "R10", "seed flag before events", seed_valid, 0);

    // directed: shortest and full-width words, before the seed is complete
    do_req(1, 1'b0);
    do_req(0, 1'b0);
    // idle run: only injections move the register (R3)
    for (int i = 0; i < 12; i++) begin
      repeat (80) @(negedge clk);
      chk(seed_valid == (m_abs >= 32), "R5", "seed flag while idle", seed_valid, m_abs >= 32);
    end
    do_req(0, 1'b0);
    // request held high across the busy period (R9)
    do_req(5, 1'b1);
    do_req(2, 1'b1);

    // random mix of lengths, gaps and held requests (R8 collisions)
    for (int i = 0; i < 60; i++) begin
      int gap;
      gap = int'($urandom_range(0, 25));
      repeat (gap) @(negedge clk);
      do_req(int'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule